// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block sits between a small processor core and its interrupt logic. The core tells it when the current instruction has fully finished. At that boundary it may accept an interrupt request that carries a source index and an urgency level. It accepts the request only when that level is strictly above the priority field of the core's current status word. It then saves the status word and the return address on a hardware-owned stack and reads the handler address from a vector table. It hands the core a new status word, with the priority raised and supervisor mode set, and redirects instruction fetch to the handler.

A return command, also taken at an instruction boundary, reverses this. The sequencer pops the return address and then the saved status word, hands the status back to the core, and redirects fetch to the popped address. The stack pointer counts down as words are pushed. Entries therefore nest: each return unwinds exactly one level. While the sequencer is saving, reading or restoring, it holds `busy` high and the core stalls fetch. All memory traffic uses a single request/acknowledge port.

Top module: `isq_seq`

## Requirements
- R1: After a synchronous reset, `busy`, `irq_ack`, `redirect`, `psw_load` and `mem_req` are all low.
- R2: A request is accepted only when `irq_valid` and `instr_done` are both high, the sequencer is idle, and `irq_level` is strictly greater than `psw_in[10:8]`. On acceptance, `irq_ack` pulses for one cycle right after the sampling edge. With any of these conditions missing, no acknowledge and no memory access occur.
- R3: On entry, the sequencer first writes the status word sampled at acceptance to address SP-1. It then writes the sampled `pc_in` to SP-2. The stack pointer starts at the parameter STACK_TOP and decreases by one per pushed word.
- R4: After both pushes, the sequencer reads address VEC_BASE + `irq_src`. In the cycle after that read is acknowledged, `redirect` pulses with `redirect_pc` equal to the word that was read.
- R5: In the same cycle as that `redirect`, `psw_load` pulses. `psw_new` equals the saved status word with bit 15 (privilege) set to 1 and bits [10:8] replaced by the accepted level. All other bits are unchanged.
- R6: Once a request has been accepted, no further request is acknowledged until the entry has finished. A request held high across an entry is acknowledged exactly once.
- R7: A return command (`rti_req` with `instr_done`, while idle) reads the PC from SP, then the status word from SP+1, and advances SP by one per word. In the cycle after the second read is acknowledged, `redirect` pulses with the popped PC, and `psw_load` pulses with the popped status word.
- R8: Two nested entries followed by two returns restore, in reverse order, each saved PC and status word exactly. The stack pointer ends back at STACK_TOP.
- R9: A request is refused when fewer than two stack words are free. A return command is ignored when the stack is empty. In both cases there is no acknowledge and no memory access.
- R10: While `mem_req` is high and not acknowledged, `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` stay stable into the next cycle.
- R11: If a return command and an acceptable request arrive at the same boundary, the return is taken and the request is not acknowledged.
- R12: `busy` is high from the cycle after acceptance until the last memory access of the sequence has been acknowledged. `mem_req` is never high while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_done | input | 1 | Current instruction has fully completed (boundary) |
| irq_valid | input | 1 | Interrupt request pending |
| irq_src | input | SRCW | Source index of the request |
| irq_level | input | 3 | Priority level of the request |
| irq_ack | output | 1 | One-cycle pulse: request accepted |
| rti_req | input | 1 | Return-from-interrupt command |
| pc_in | input | 16 | Return address of the interrupted program |
| psw_in | input | 16 | Core's current status word |
| psw_load | output | 1 | One-cycle pulse: core loads `psw_new` |
| psw_new | output | 16 | Status word for the core to load |
| redirect | output | 1 | One-cycle pulse: fetch from `redirect_pc` |
| redirect_pc | output | 16 | New fetch address |
| busy | output | 1 | Sequence in progress; core stalls fetch |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Memory access completed |

## Verification
The bench builds the block with an 8-bit address, STACK_TOP of 0xF0, a vector base of 0x40 and a stack of only four words. That stack holds exactly two nested entries, so a third request meets the full-stack refusal and a third return meets the empty-stack case within a few dozen cycles. The bench's memory model answers with a latency that each scenario sets, from zero to two wait cycles. This exercises the stable-request rule as well as the back-to-back acknowledge path.

// File: rtl/isq_pkg.sv
package isq_pkg;
  localparam int DW      = 16;
  localparam int PRIV_B  = 15;
  localparam int PL_LO   = 8;
  localparam int PL_HI   = 10;

  typedef enum logic [2:0] {
    S_IDLE, S_PUSH_PSW, S_PUSH_PC, S_VEC, S_POP_PC, S_POP_PSW
  } seq_state_t;

  function automatic logic [DW-1:0] psw_enter(input logic [DW-1:0] psw,
                                              input logic [2:0]    lvl);
    logic [DW-1:0] r;
    r = psw;
    r[PRIV_B]      = 1'b1;
    r[PL_HI:PL_LO] = lvl;
    return r;
  endfunction
endpackage

// File: rtl/isq_stack_ptr.sv
module isq_stack_ptr #(
  parameter int AW = 16,
  parameter logic [AW-1:0] STACK_TOP = '1,
  parameter int STACK_WORDS = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  output logic [AW-1:0] sp,
  output logic          room2,
  output logic          empty
);
  localparam logic [AW-1:0] BOT = STACK_TOP - AW'(STACK_WORDS);

  logic [AW-1:0] free_w;

  always_ff @(posedge clk) begin
    if (rst)       sp <= STACK_TOP;
    else if (push) sp <= sp - 1'b1;
    else if (pop)  sp <= sp + 1'b1;
  end

  assign free_w = sp - BOT;
  assign room2  = free_w >= AW'(2);
  assign empty  = (sp == STACK_TOP);
endmodule

// File: rtl/isq_gate.sv
module isq_gate (
  input  logic       idle,
  input  logic       instr_done,
  input  logic       irq_valid,
  input  logic [2:0] irq_level,
  input  logic [2:0] cur_level,
  input  logic       rti_req,
  input  logic       room2,
  input  logic       empty,
  input  logic       psw_pending,
  output logic       take_irq,
  output logic       take_rti
);
  logic boundary;

  always_comb begin
    boundary = idle && instr_done && !psw_pending;
    take_rti = boundary && rti_req && !empty;
    take_irq = boundary && irq_valid && (irq_level > cur_level)
               && room2 && !take_rti;
  end
endmodule

// File: rtl/isq_seq.sv
module isq_seq
  import isq_pkg::*;
#(
  parameter int AW = 16,
  parameter int SRCW = 8,
  parameter logic [AW-1:0] STACK_TOP = 16'hFF00,
  parameter int STACK_WORDS = 64,
  parameter logic [AW-1:0] VEC_BASE = 16'hFF80
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            instr_done,
  input  logic            irq_valid,
  input  logic [SRCW-1:0] irq_src,
  input  logic [2:0]      irq_level,
  output logic            irq_ack,
  input  logic            rti_req,
  input  logic [15:0]     pc_in,
  input  logic [15:0]     psw_in,
  output logic            psw_load,
  output logic [15:0]     psw_new,
  output logic            redirect,
  output logic [15:0]     redirect_pc,
  output logic            busy,
  output logic            mem_req,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [15:0]     mem_wdata,
  input  logic [15:0]     mem_rdata,
  input  logic            mem_ack
);
  seq_state_t      state;
  logic [DW-1:0]   sv_psw, sv_pc, pop_pc;
  logic [SRCW-1:0] sv_src;
  logic [2:0]      sv_lvl;
  logic [AW-1:0]   sp;
  logic            room2, empty, take_irq, take_rti, do_push, do_pop;

  assign do_push = mem_ack && (state == S_PUSH_PSW || state == S_PUSH_PC);
  assign do_pop  = mem_ack && (state == S_POP_PC || state == S_POP_PSW);

  isq_stack_ptr #(.AW(AW), .STACK_TOP(STACK_TOP), .STACK_WORDS(STACK_WORDS)) u_sp (
    .clk(clk), .rst(rst), .push(do_push), .pop(do_pop),
    .sp(sp), .room2(room2), .empty(empty)
  );

  isq_gate u_gate (
    .idle(state == S_IDLE), .instr_done(instr_done), .irq_valid(irq_valid),
    .irq_level(irq_level), .cur_level(psw_in[PL_HI:PL_LO]), .rti_req(rti_req),
    .room2(room2), .empty(empty), .psw_pending(psw_load),
    .take_irq(take_irq), .take_rti(take_rti)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= S_IDLE;
      irq_ack     <= 1'b0;
      redirect    <= 1'b0;
      psw_load    <= 1'b0;
      redirect_pc <= '0;
      psw_new     <= '0;
      sv_psw      <= '0;
      sv_pc       <= '0;
      sv_src      <= '0;
      sv_lvl      <= '0;
      pop_pc      <= '0;
    end else begin
      irq_ack  <= 1'b0;
      redirect <= 1'b0;
      psw_load <= 1'b0;
      case (state)
        S_IDLE: begin
          if (take_rti) begin
            state <= S_POP_PC;
          end else if (take_irq) begin
            state   <= S_PUSH_PSW;
            irq_ack <= 1'b1;
            sv_psw  <= psw_in;
            sv_pc   <= pc_in;
            sv_src  <= irq_src;
            sv_lvl  <= irq_level;
          end
        end
        S_PUSH_PSW: if (mem_ack) state <= S_PUSH_PC;
        S_PUSH_PC:  if (mem_ack) state <= S_VEC;
        S_VEC: if (mem_ack) begin
          state       <= S_IDLE;
          redirect    <= 1'b1;
          redirect_pc <= mem_rdata;
          psw_load    <= 1'b1;
          psw_new     <= psw_enter(sv_psw, sv_lvl);
        end
        S_POP_PC: if (mem_ack) begin
          pop_pc <= mem_rdata;
          state  <= S_POP_PSW;
        end
        S_POP_PSW: if (mem_ack) begin
          state       <= S_IDLE;
          redirect    <= 1'b1;
          redirect_pc <= pop_pc;
          psw_load    <= 1'b1;
          psw_new     <= mem_rdata;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    busy      = (state != S_IDLE);
    mem_req   = busy;
    mem_we    = (state == S_PUSH_PSW) || (state == S_PUSH_PC);
    mem_wdata = (state == S_PUSH_PSW) ? sv_psw :
                (state == S_PUSH_PC)  ? sv_pc  : '0;
    case (state)
      S_PUSH_PSW, S_PUSH_PC: mem_addr = sp - 1'b1;
      S_VEC:                 mem_addr = VEC_BASE + AW'(sv_src);
      default:               mem_addr = sp;
    endcase
  end
endmodule

// File: rtl/isq_seq_chk.sv
module isq_seq_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          irq_ack,
  input logic          redirect,
  input logic          psw_load,
  input logic          busy,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [15:0]   mem_wdata,
  input logic          mem_ack
);
  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!busy && !mem_req && !irq_ack && !redirect));

  assert_single_ack_R6: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> !irq_ack);

  assert_ack_starts_busy_R12: assert property (@(posedge clk) disable iff (rst)
    irq_ack |-> busy);

  assert_req_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                               && $stable(mem_wdata)));

  assert_redirect_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    redirect |=> !redirect);

  assert_redirect_idle_R7: assert property (@(posedge clk) disable iff (rst)
    redirect |-> (!busy && psw_load));

  assert_no_idle_req_R12: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_req);
endmodule

bind isq_seq isq_seq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .irq_ack(irq_ack), .redirect(redirect),
  .psw_load(psw_load), .busy(busy), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack)
);

// File: tb/isq_seq_tb.sv
module isq_seq_tb;
  localparam int AW = 8;
  localparam logic [7:0] TOP = 8'hF0;
  localparam logic [7:0] VB  = 8'h40;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst, instr_done, irq_valid, rti_req, irq_ack, psw_load, redirect, busy;
  logic mem_req, mem_we, mem_ack;
  logic [7:0] irq_src, mem_addr;
  logic [2:0] irq_level;
  logic [15:0] pc_in, psw_core, psw_new, redirect_pc, mem_wdata, mem_rdata;

  isq_seq #(.AW(AW), .SRCW(8), .STACK_TOP(TOP), .STACK_WORDS(4), .VEC_BASE(VB)) u_dut (
    .clk(clk), .rst(rst), .instr_done(instr_done), .irq_valid(irq_valid),
    .irq_src(irq_src), .irq_level(irq_level), .irq_ack(irq_ack), .rti_req(rti_req),
    .pc_in(pc_in), .psw_in(psw_core), .psw_load(psw_load), .psw_new(psw_new),
    .redirect(redirect), .redirect_pc(redirect_pc), .busy(busy), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  logic [15:0] mem [256];
  logic        lg_we [128];
  logic [7:0]  lg_addr [128];
  logic [15:0] lg_data [128];
  logic [15:0] rd_pc [64];
  int lg_n = 0, rd_n = 0, ack_n = 0, lat = 0, cnt = 0, viol = 0;
  logic p_pend = 1'b0;
  logic [7:0] p_addr = '0;
  int checks = 0, errors = 0;

  function automatic logic [15:0] vec(input int i);
    return 16'hA000 + 16'(i) * 16'h0011;
  endfunction

  assign mem_rdata = mem[mem_addr];

  always @(posedge clk) begin
    if (rst) begin
      mem_ack <= 1'b0; cnt <= 0;
    end else if (mem_req && !mem_ack) begin
      if (cnt >= lat) begin mem_ack <= 1'b1; cnt <= 0; end
      else cnt <= cnt + 1;
    end else mem_ack <= 1'b0;
    if (mem_req && mem_ack) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      lg_we[lg_n]   <= mem_we;
      lg_addr[lg_n] <= mem_addr;
      lg_data[lg_n] <= mem_we ? mem_wdata : mem_rdata;
      lg_n <= lg_n + 1;
    end
    if (p_pend && (!mem_req || mem_addr != p_addr)) viol <= viol + 1;
    p_pend <= mem_req && !mem_ack;
    p_addr <= mem_addr;
    if (psw_load) psw_core <= psw_new;
    if (redirect) begin rd_pc[rd_n] <= redirect_pc; rd_n <= rd_n + 1; end
    if (irq_ack) ack_n <= ack_n + 1;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 60 && busy; i++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic chk_log(input string tag, input int idx, input logic we,
                         input logic [7:0] a, input logic [15:0] d);
    chk({tag, " we"},   {31'd0, lg_we[idx]}, {31'd0, we});
    chk({tag, " addr"}, {24'd0, lg_addr[idx]}, {24'd0, a});
    chk({tag, " data"}, {16'd0, lg_data[idx]}, {16'd0, d});
  endtask

  // one boundary with an interrupt request, returns whether acknowledged
  task automatic raise(input logic [7:0] src, input logic [2:0] lvl,
                       input logic [15:0] pc, output logic acked);
    irq_src = src; irq_level = lvl; pc_in = pc; irq_valid = 1'b1; instr_done = 1'b1;
    @(negedge clk);
    acked = irq_ack;
    irq_valid = 1'b0; instr_done = 1'b0;
  endtask

  task automatic do_rti();
    rti_req = 1'b1; instr_done = 1'b1;
    @(negedge clk);
    rti_req = 1'b0; instr_done = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 busy", {31'd0, busy}, 0);
    chk("R1 mem_req", {31'd0, mem_req}, 0);
    chk("R1 irq_ack", {31'd0, irq_ack}, 0);
    chk("R1 redirect", {31'd0, redirect}, 0);
    chk("R1 psw_load", {31'd0, psw_load}, 0);
  endtask

  task automatic t_refuse();
    int b;
    logic a;
    b = lg_n;
    psw_core = 16'h0305;
    raise(8'd2, 3'd3, 16'h0100, a);
    chk("R2 equal level refused", {31'd0, a}, 0);
    irq_src = 8'd2; irq_level = 3'd6; irq_valid = 1'b1; instr_done = 1'b0;
    repeat (3) @(negedge clk);
    irq_valid = 1'b0;
    chk("R2 mid-instruction no ack", ack_n, 0);
    chk("R2 no memory traffic", lg_n - b, 0);
  endtask

  task automatic t_entry();
    int b, r;
    logic a;
    lat = 0; b = lg_n; r = rd_n;
    psw_core = 16'h0205;
    raise(8'd5, 3'd6, 16'h1234, a);
    chk("R2 accepted ack", {31'd0, a}, 1);
    chk("R12 busy after accept", {31'd0, busy}, 1);
    wait_idle();
    chk("R12 busy low after entry", {31'd0, busy}, 0);
    chk("R3 three accesses", lg_n - b, 3);
    chk_log("R3 psw push", b, 1'b1, 8'hEF, 16'h0205);
    chk_log("R3 pc push", b + 1, 1'b1, 8'hEE, 16'h1234);
    chk_log("R4 vector read", b + 2, 1'b0, 8'h45, vec(5));
    chk("R4 redirect pc", {16'd0, rd_pc[r]}, {16'd0, vec(5)});
    chk("R5 new psw", {16'd0, psw_core}, 32'h8605);
  endtask

  task automatic t_nest_full();
    int b, r;
    logic a;
    lat = 2; b = lg_n; r = rd_n;
    raise(8'd9, 3'd7, 16'h2000, a);
    chk("R8 nested accepted", {31'd0, a}, 1);
    wait_idle();
    chk_log("R8 nested psw push", b, 1'b1, 8'hED, 16'h8605);
    chk_log("R8 nested pc push", b + 1, 1'b1, 8'hEC, 16'h2000);
    chk("R8 nested redirect", {16'd0, rd_pc[r]}, {16'd0, vec(9)});
    chk("R5 nested psw", {16'd0, psw_core}, 32'h8705);
    // lower the status priority so only the full stack can refuse
    psw_core = 16'h8005;
    b = lg_n;
    raise(8'd3, 3'd2, 16'h3000, a);
    repeat (3) @(negedge clk);
    chk("R9 full stack refused", {31'd0, a}, 0);
    chk("R9 full stack no access", lg_n - b, 0);
    psw_core = 16'h8705;
  endtask

  task automatic t_unwind();
    int b, r;
    lat = 1; b = lg_n; r = rd_n;
    do_rti();
    wait_idle();
    chk_log("R7 pop pc", b, 1'b0, 8'hEC, 16'h2000);
    chk_log("R7 pop psw", b + 1, 1'b0, 8'hED, 16'h8605);
    chk("R7 redirect popped pc", {16'd0, rd_pc[r]}, 32'h2000);
    chk("R7 psw restored", {16'd0, psw_core}, 32'h8605);
    do_rti();
    wait_idle();
    chk("R8 outer pc restored", {16'd0, rd_pc[r + 1]}, 32'h1234);
    chk("R8 outer psw restored", {16'd0, psw_core}, 32'h0205);
    chk_log("R8 last pop address", b + 3, 1'b0, 8'hEF, 16'h0205);
    b = lg_n;
    do_rti();
    repeat (3) @(negedge clk);
    chk("R9 empty return ignored", lg_n - b, 0);
    chk("R9 empty return not busy", {31'd0, busy}, 0);
  endtask

  task automatic t_hold_and_race();
    int b, a0;
    lat = 0; a0 = ack_n;
    psw_core = 16'h0000;
    irq_src = 8'd1; irq_level = 3'd5; pc_in = 16'h4000;
    irq_valid = 1'b1; instr_done = 1'b1;
    repeat (20) @(negedge clk);
    irq_valid = 1'b0; instr_done = 1'b0;
    chk("R6 held request acked once", ack_n - a0, 1);
    chk("R6 level raised", {16'd0, psw_core}, 32'h8500);
    psw_core = 16'h0000;
    a0 = ack_n; b = lg_n;
    irq_src = 8'd2; irq_level = 3'd4; irq_valid = 1'b1; rti_req = 1'b1; instr_done = 1'b1;
    @(negedge clk);
    irq_valid = 1'b0; rti_req = 1'b0; instr_done = 1'b0;
    wait_idle();
    chk("R11 return wins no ack", ack_n - a0, 0);
    chk_log("R11 return pops first", b, 1'b0, 8'hEE, 16'h4000);
    chk("R11 psw from stack", {16'd0, psw_core}, 32'h0000);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = (i >= 64 && i < 128) ? vec(i - 64) : 16'h0;
    rst = 1'b1; instr_done = 1'b0; irq_valid = 1'b0; rti_req = 1'b0;
    irq_src = '0; irq_level = '0; pc_in = '0; psw_core = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_refuse();
    t_entry();
    t_nest_full();
    t_unwind();
    t_hold_and_race();
    chk("R10 request stable until ack", viol, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule